// File: doc/BRIEF.md
# Lockable Security Control Register

A 32-bit control word for security-related settings, reached through a simple word-access register bus with write enable, word address, write data and read data. Beside the control word sit a sticky lock register and a key register. Each lock bit freezes one group of control fields. Once a lock bit is set, only a reset clears it.

Writing the correct key to the key register re-arms the programming path. Writing any other value closes the whole register window until the next reset. The block outputs the live control word and an access-enabled flag. When a committed control write leaves the encryption-enable field in a mixed state, the block raises a one-cycle warning pulse.

Top module: `sec_ctrl_reg`

## Requirements
- R1: After reset the control word is 0x0C006000, the lock value is 0, access is enabled and the warning pulse is low.
- R2: Word address 0 selects the control word, word address 1 selects the lock register (read in bits 4:0, upper bits zero) and word address 2 selects the key register (always reads 0). While access is enabled, reads return the addressed value combinationally.
- R3: A control write changes only the bits in mask 0x0D009FFF (bits 27, 26, 24, 15 and 12:0). The force-reset bit 31 and all other bits keep their reset values.
- R4: A lock write ORs bits 4:0 of the write data into the lock value, so set bits stay set until reset.
- R5: Lock bit 0 freezes control bits 6:0. Lock bit 1 freezes bit 7. Lock bit 2 freezes bit 8. Lock bit 3 freezes the encryption-enable field at bits 11:9. Lock bit 4 freezes bit 12. Unfrozen writable bits take the written value.
- R6: Writing 0x757BDF0D to the key register sets bit 27 and bits 11:9 whatever the lock value is, and leaves access enabled.
- R7: Writing any other value to the key register clears bit 27 and bits 11:9 and disables access. While access is disabled, reads return 0, writes are dropped (the key included) and access stays off until reset.
- R8: A committed control write whose resulting bits 11:9 are neither 000 nor 111 raises the warning pulse for exactly the one cycle after the write edge.
- R9: Every register update becomes visible on the outputs in the cycle right after the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W (4) | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| ctrl_o | output | 32 | Current control word |
| access_en_o | output | 1 | Register window open |
| aes_inconsistent_o | output | 1 | One-cycle mixed encryption-enable warning |

## Verification
All register state (control word, lock value and access flag) changes at the clock edge that samples the write, and the warning pulse is registered at that same edge. The bench therefore drives each write on a falling edge and samples ctrl_o, rdata_o, access_en_o and the pulse at the next falling edge. It samples the pulse once more one cycle later to confirm that it has dropped. Because reads are combinational, read data is compared in the half cycle after the address is applied, with no wait for a clock edge.

// File: rtl/sec_ctrl_pkg.sv
package sec_ctrl_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned LOCK_W     = 5;
  localparam int unsigned AES_LO     = 9;
  localparam int unsigned AES_W      = 3;
  localparam int unsigned PROG_BIT   = 27;
  localparam logic [DATA_W-1:0] CTRL_RST   = 32'h0C00_6000;
  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h0D00_9FFF;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h757B_DF0D;
  localparam logic [DATA_W-1:0] AES_MASK   = ((DATA_W'(1) << AES_W) - 1) << AES_LO;
  localparam logic [DATA_W-1:0] ARM_MASK   = AES_MASK | (DATA_W'(1) << PROG_BIT);

  function automatic logic [DATA_W-1:0] lock_field_mask(input int idx);
    case (idx)
      0:       return 32'h0000_007F;
      1:       return 32'h0000_0080;
      2:       return 32'h0000_0100;
      3:       return AES_MASK;
      4:       return 32'h0000_1000;
      default: return '0;
    endcase
  endfunction

  function automatic logic aes_mixed(input logic [AES_W-1:0] f);
    return (f != '0) && (f != '1);
  endfunction
endpackage

// File: rtl/sec_lock_reg.sv
module sec_lock_reg #(
  parameter int unsigned LOCK_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [LOCK_W-1:0] wdata_i,
  output logic [LOCK_W-1:0] lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   lock_o <= '0;
    else if (wr_i) lock_o <= lock_o | wdata_i;

  a_r4_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(lock_o) & ~lock_o) == '0));
endmodule

// File: rtl/sec_ctrl_merge.sv
module sec_ctrl_merge
  import sec_ctrl_pkg::*;
#(
  parameter int unsigned LW = LOCK_W
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LW-1:0]     lock_i,
  output logic [DATA_W-1:0] prot_o,
  output logic [DATA_W-1:0] next_o
);
  logic [DATA_W-1:0] part [LW];

  for (genvar g = 0; g < LW; g++) begin : g_lock
    assign part[g] = lock_i[g] ? lock_field_mask(g) : '0;
  end

  always_comb begin
    prot_o = '0;
    for (int i = 0; i < LW; i++) prot_o |= part[i];
  end

  logic [DATA_W-1:0] take;
  assign take   = CTRL_WMASK & ~prot_o;
  assign next_o = (wdata_i & take) | (cur_i & ~take);
endmodule

// File: rtl/sec_unlock_gate.sv
module sec_unlock_gate
  import sec_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] key_i,
  output logic              arm_o,
  output logic              kill_o,
  output logic              access_o
);
  assign arm_o  = wr_i && (key_i == UNLOCK_KEY);
  assign kill_o = wr_i && (key_i != UNLOCK_KEY);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     access_o <= 1'b1;
    else if (kill_o) access_o <= 1'b0;

  a_r7_access_stays_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_o |=> !access_o);
endmodule

// File: rtl/sec_ctrl_reg.sv
module sec_ctrl_reg
  import sec_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CTRL_ADDR   = 0,
  parameter int unsigned LOCK_ADDR   = 1,
  parameter int unsigned UNLOCK_ADDR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [31:0]       ctrl_o,
  output logic              access_en_o,
  output logic              aes_inconsistent_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(LOCK_ADDR);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(UNLOCK_ADDR);

  logic              wr_ok, ctrl_wr, lock_wr, key_wr, arm, kill;
  logic [LOCK_W-1:0] lock_q;
  logic [DATA_W-1:0] ctrl_q, ctrl_nxt, prot;

  assign wr_ok   = we_i && access_en_o;
  assign ctrl_wr = wr_ok && (addr_i == A_CTRL);
  assign lock_wr = wr_ok && (addr_i == A_LOCK);
  assign key_wr  = wr_ok && (addr_i == A_KEY);

  sec_lock_reg #(.LOCK_W(LOCK_W)) u_lock (
    .clk_i, .rst_ni, .wr_i(lock_wr), .wdata_i(wdata_i[LOCK_W-1:0]), .lock_o(lock_q)
  );

  sec_ctrl_merge #(.LW(LOCK_W)) u_merge (
    .cur_i(ctrl_q), .wdata_i, .lock_i(lock_q), .prot_o(prot), .next_o(ctrl_nxt)
  );

  sec_unlock_gate u_gate (
    .clk_i, .rst_ni, .wr_i(key_wr), .key_i(wdata_i),
    .arm_o(arm), .kill_o(kill), .access_o(access_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctrl_q             <= CTRL_RST;
      aes_inconsistent_o <= 1'b0;
    end else begin
      aes_inconsistent_o <= ctrl_wr && aes_mixed(ctrl_nxt[AES_LO +: AES_W]);
      if (ctrl_wr)   ctrl_q <= ctrl_nxt;
      else if (arm)  ctrl_q <= ctrl_q | ARM_MASK;  // key overrides locks
      else if (kill) ctrl_q <= ctrl_q & ~ARM_MASK;
    end

  assign ctrl_o = ctrl_q;

  always_comb begin
    rdata_o = '0;
    if (access_en_o)
      unique case (addr_i)
        A_CTRL:  rdata_o = ctrl_q;
        A_LOCK:  rdata_o = 32'(lock_q);
        default: rdata_o = '0;
      endcase
  end

  a_r3_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl_o ^ CTRL_RST) & ~CTRL_WMASK) == '0);

  a_r5_locked_fields_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (((ctrl_o ^ $past(ctrl_o)) & $past(prot)) == '0));

  a_r8_pulse_only_on_mixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aes_inconsistent_o |-> aes_mixed(ctrl_o[AES_LO +: AES_W]));

  a_r7_closed_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_en_o |-> (rdata_o == '0));

  a_r6_key_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> (((ctrl_o & ARM_MASK) == ARM_MASK) && access_en_o));
endmodule

// File: tb/sec_ctrl_reg_test.sv
`timescale 1ns/1ps
module sec_ctrl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, ctrl;
  logic        acc, pulse;
  int checks = 0, errors = 0;

  localparam logic [31:0] RST_V = 32'h0C00_6000;
  localparam logic [31:0] WM    = 32'h0D00_9FFF;
  localparam logic [31:0] KEY   = 32'h757B_DF0D;
  localparam logic [31:0] ARM   = 32'h0800_0E00;

  always #2.5 clk = ~clk;

  sec_ctrl_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ctrl_o(ctrl), .access_en_o(acc), .aes_inconsistent_o(pulse)
  );

  function automatic logic [31:0] lmask(input logic [4:0] l);
    logic [31:0] m = 0;
    if (l[0]) m |= 32'h7F;
    if (l[1]) m |= 32'h80;
    if (l[2]) m |= 32'h100;
    if (l[3]) m |= 32'hE00;
    if (l[4]) m |= 32'h1000;
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; we = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, exp, prev, m;
    do_reset();
    // R1
    chk("R1 ctrl", ctrl, RST_V);
    chk("R1 access", 32'(acc), 32'd1);
    chk("R1 pulse", 32'(pulse), 32'd0);
    rd(4'd1, r); chk("R1 R2 lock read", r, 32'd0);
    rd(4'd0, r); chk("R2 ctrl read", r, RST_V);
    rd(4'd2, r); chk("R2 key read", r, 32'd0);

    // R3 R5 R9: sweep every lock value
    for (int l = 0; l < 32; l++) begin
      do_reset();
      wr(4'd1, 32'hFFFF_FFE0 | 32'(l));
      rd(4'd1, r); chk("R4 lock upper bits masked", r, 32'(l));
      m = lmask(5'(l));
      prev = ctrl;
      wr(4'd0, 32'hFFFF_FFFF);
      exp = (prev & ~(WM & ~m)) | (32'hFFFF_FFFF & WM & ~m);
      chk("R5 R3 R9 set-all write", ctrl, exp);
      prev = ctrl;
      wr(4'd0, 32'h0);
      exp = prev & ~(WM & ~m);
      chk("R5 R3 clear-all write", ctrl, exp);
      rd(4'd0, r); chk("R2 ctrl readback", r, exp);
      chk("R3 force bit low", 32'(ctrl[31]), 32'd0);
    end

    // R4: sticky OR
    do_reset();
    wr(4'd1, 32'h05);
    wr(4'd1, 32'h12);
    rd(4'd1, r); chk("R4 OR accumulates", r, 32'h17);
    wr(4'd1, 32'h0);
    rd(4'd1, r); chk("R4 zero write keeps", r, 32'h17);

    // R8: pulse sweep over encryption-enable values
    do_reset();
    for (int a = 0; a < 8; a++) begin
      wr(4'd0, 32'(a) << 9);
      chk("R8 pulse after write", 32'(pulse), 32'((a != 0) && (a != 7)));
      @(negedge clk);
      chk("R8 pulse one cycle", 32'(pulse), 32'd0);
    end
    // R8: locked field keeps 000 though mixed value written -> no pulse
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h08);
    wr(4'd0, 32'h0000_0A00);
    chk("R8 R5 locked aes no pulse", 32'(pulse), 32'd0);
    // R8: key write arming the field does not pulse
    do_reset();
    wr(4'd0, 32'h0000_0200);
    @(negedge clk);
    wr(4'd2, KEY);
    chk("R8 key no pulse", 32'(pulse), 32'd0);

    // R6: key overrides locks
    do_reset();
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h1F);
    prev = ctrl;
    wr(4'd2, KEY);
    chk("R6 arm bits set", ctrl, prev | ARM);
    chk("R6 access kept", 32'(acc), 32'd1);

    // R7: bad key closes window
    prev = ctrl;
    wr(4'd2, 32'h1234_5678);
    chk("R7 arm bits cleared", ctrl, prev & ~ARM);
    chk("R7 access off", 32'(acc), 32'd0);
    rd(4'd0, r); chk("R7 ctrl read zero", r, 32'd0);
    rd(4'd1, r); chk("R7 lock read zero", r, 32'd0);
    prev = ctrl;
    wr(4'd0, 32'h0400_0000);
    chk("R7 ctrl write dropped", ctrl, prev);
    chk("R7 dropped write no pulse", 32'(pulse), 32'd0);
    wr(4'd2, KEY);
    chk("R7 key ignored while closed", 32'(acc), 32'd0);
    chk("R7 key ignored ctrl", ctrl, prev);
    do_reset();
    chk("R7 R1 reset reopens", 32'(acc), 32'd1);
    rd(4'd1, r); chk("R7 R1 lock cleared", r, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule